// File: doc/BRIEF.md
# Converter Calibration and Acquisition Sequencer

This block runs the complete flow of a slow, isolated 24-bit delta-sigma converter. It sits above a serial port master that owns all bit timing. After reset it asks the port master for one configuration write. That write both sets up the converter and starts its self-calibration. The block then watches the converter's ready line until calibration ends. After that it loops: it settles the channel-select lines, waits for a fresh conversion, and asks the port master for a data-register read.

A requested channel is applied only while no transfer is running. Every channel switch makes the block drop the next conversion, because that result may mix the old and new inputs. Each kept conversion comes out with a one-cycle strobe, the channel it was taken on, the raw offset-binary code and the same value in two's complement. If calibration does not finish within a set number of cycles, a sticky error stops the block until the next reset.

Top module: `adcseq_top`

## Requirements
- R1: After reset the block issues exactly one configuration write (`xfer_write`=1). Its word is 0x22004E, with bit 15 set to the value of `long_word`. Bits 23:21 are therefore 001, which starts self-calibration, and the gain bits 20:18 are 000 (gain 1).
- R2: After the write the block treats calibration as done on the first cycle that `adc_rdy_n` is low. It never issues a second configuration write.
- R3: If `adc_rdy_n` stays high for `CAL_TIMEOUT` cycles after the write completes, `cal_error` rises. It stays high until reset, and no further transfer is requested.
- R4: `chan_sel` carries the binary code of the active input: 000 is input 1 and 111 is input 8. It takes the value of `req_chan` only while no transfer is requested, so a change requested during a read is applied after that read.
- R5: A data read (`xfer_req`=1, `xfer_write`=0) starts only after `adc_rdy_n` has been seen low while no transfer was active. After each read the block waits for `adc_rdy_n` to go high again.
- R6: After every channel change, the first completed read gives no `smp_valid`. The second read gives one `smp_valid`.
- R7: Reads request 24 bits (`xfer_long`=1) when the latched word-length bit is 1, and 16 bits otherwise. In 16-bit mode `smp_raw` holds the read value in bits 15:0, and bits 23:16 are zero.
- R8: `smp_twos` equals `smp_raw` minus 2^23 in 24-bit mode. In 16-bit mode it is `smp_raw` minus 2^15, sign-extended to 24 bits. This means the most significant bit of the offset-binary code is inverted.
- R9: `smp_chan` is the `chan_sel` code that was active while the reported conversion was read.
- R10: While `enable` is low, no read is started and no channel change is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows channel changes and reads |
| req_chan | input | CH_W | Requested channel code |
| long_word | input | 1 | Word length for the configuration: 1 = 24 bits, 0 = 16 bits |
| adc_rdy_n | input | 1 | Converter data-out level between transfers; low = ready |
| xfer_req | output | 1 | Transfer request to the port master, held until done |
| xfer_write | output | 1 | 1 = configuration write, 0 = data-register read |
| xfer_long | output | 1 | Bit count for the transfer: 1 = 24, 0 = 16 |
| xfer_wdata | output | 24 | Configuration word for a write |
| xfer_done | input | 1 | One-cycle pulse from the port master when the transfer ends |
| xfer_rdata | input | 24 | Read value, right-aligned, valid with `xfer_done` |
| chan_sel | output | CH_W | Channel-select lines |
| smp_valid | output | 1 | One-cycle strobe for a kept sample |
| smp_raw | output | 24 | Offset-binary sample |
| smp_twos | output | 24 | Two's-complement sample |
| smp_chan | output | CH_W | Channel tag of the sample |
| cal_error | output | 1 | Sticky calibration timeout |

## Verification
The acquisition loop is swept over every channel code in both word lengths. Each channel gets a throw-away conversion and then a kept one. The kept codes include zero, mid-scale, full scale, mid-scale minus one and asymmetric patterns, so they separate a correct MSB flip and sign extension from a plain copy, a wrong bit position or a wrong width. One channel request is made while a read is in flight: this tells a change deferred to the gap apart from an immediate one, and shows the in-flight result keeps its old tag. A ready pulse while `enable` is low, and a calibration that never ends, check that reads are held off and that the error stays sticky.

// File: rtl/adcseq_pkg.sv
// Shared constants and state type for the converter sequencer.
package adcseq_pkg;
    localparam int          WORD_W   = 24;
    localparam int          SHORT_W  = 16;
    localparam int          WL_POS   = 15;
    localparam logic [23:0] CFG_INIT = 24'h22004E;

    typedef enum logic [2:0] {
        S_CFG   = 3'd0,
        S_CAL   = 3'd1,
        S_IDLE  = 3'd2,
        S_READ  = 3'd3,
        S_REARM = 3'd4,
        S_ERR   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/adcseq_cal_timer.sv
// Counts cycles while run is high; expired pulses on the last allowed cycle.
// Assumes run drops as soon as expired is acted on; the count restarts from zero.
module adcseq_cal_timer #(
    parameter int LIMIT = 100000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Cycle counter, cleared whenever the wait is not in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/adcseq_chan_track.sv
// Holds the channel-select lines and the count of conversions still to drop.
// Assumes take is only raised between transfers and read_done once per read.
module adcseq_chan_track #(
    parameter int CH_W      = 3,
    parameter int DISCARD_N = 1,
    localparam int DW = $clog2(DISCARD_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [CH_W-1:0] new_chan,
    input  logic            read_done,
    output logic [CH_W-1:0] chan_sel,
    output logic            drop_now
);
    logic [DW-1:0] left;

    // Channel lines: load the request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    chan_sel <= '0;
        else if (take) chan_sel <= new_chan;
    end

    // Discard budget: refilled on a switch, spent by completed reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                       left <= '0;
        else if (take)                    left <= DW'(DISCARD_N);
        else if (read_done && left != '0) left <= left - 1'b1;
    end

    assign drop_now = (left != '0);
endmodule

// File: rtl/adcseq_fmt.sv
// Registers a kept read into offset-binary and two's-complement forms plus tag.
// Assumes rdata is right-aligned; in short mode only the low SHORT_W bits count.
module adcseq_fmt
    import adcseq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              long_mode,
    input  logic [WORD_W-1:0] rdata,
    input  logic [CH_W-1:0]   tag,
    output logic              valid,
    output logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] twos,
    output logic [CH_W-1:0]   chan
);
    localparam int PAD = WORD_W - SHORT_W;

    logic [WORD_W-1:0] raw_c, twos_c;

    // Width select, MSB flip and sign extension.
    always_comb begin
        if (long_mode) begin
            raw_c  = rdata;
            twos_c = {~rdata[WORD_W-1], rdata[WORD_W-2:0]};
        end else begin
            raw_c  = {{PAD{1'b0}}, rdata[SHORT_W-1:0]};
            twos_c = {{(PAD+1){~rdata[SHORT_W-1]}}, rdata[SHORT_W-2:0]};
        end
    end

    // Output register with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            raw   <= '0;
            twos  <= '0;
            chan  <= '0;
        end else begin
            valid <= load;
            if (load) begin
                raw  <= raw_c;
                twos <= twos_c;
                chan <= tag;
            end
        end
    end

    assert_twos_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((twos[WORD_W-1] != raw[WORD_W-1]) ||
                   (raw[WORD_W-1:SHORT_W] == '0 && twos[SHORT_W-1] != raw[SHORT_W-1]
                    && twos[WORD_W-1] == twos[SHORT_W-1])));
endmodule

// File: rtl/adcseq_top.sv
// Sequencer: configuration write with self-calibration, calibration wait with
// timeout, channel switching between transfers, ready-gated reads with
// post-switch discard. Assumes the port master holds xfer_done low until it
// finishes and pulses it for one cycle.
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int CAL_TIMEOUT = 100000,
    parameter int DISCARD_N   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              long_word,
    input  logic              adc_rdy_n,
    output logic              xfer_req,
    output logic              xfer_write,
    output logic              xfer_long,
    output logic [WORD_W-1:0] xfer_wdata,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] xfer_rdata,
    output logic [CH_W-1:0]   chan_sel,
    output logic              smp_valid,
    output logic [WORD_W-1:0] smp_raw,
    output logic [WORD_W-1:0] smp_twos,
    output logic [CH_W-1:0]   smp_chan,
    output logic              cal_error
);
    seq_state_t state, nxt;
    logic       wl_q;
    logic       take, rd_done, expired, drop_now;

    // Next-state decode for the whole converter flow.
    always_comb begin
        nxt     = state;
        take    = 1'b0;
        rd_done = 1'b0;
        case (state)
            S_CFG:   if (xfer_done) nxt = S_CAL;
            S_CAL: begin
                if (!adc_rdy_n)   nxt = S_IDLE;
                else if (expired) nxt = S_ERR;
            end
            S_IDLE: begin
                if (enable) begin
                    if (req_chan != chan_sel) take = 1'b1;
                    else if (!adc_rdy_n)      nxt  = S_READ;
                end
            end
            S_READ: begin
                if (xfer_done) begin
                    rd_done = 1'b1;
                    nxt     = S_REARM;
                end
            end
            S_REARM: if (adc_rdy_n) nxt = S_IDLE;
            default: nxt = S_ERR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CFG;
        else        state <= nxt;
    end

    // Word-length bit latched when the configuration write completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                            wl_q <= 1'b0;
        else if (state == S_CFG && xfer_done) wl_q <= long_word;
    end

    assign xfer_req   = (state == S_CFG) || (state == S_READ);
    assign xfer_write = (state == S_CFG);
    assign xfer_long  = (state == S_CFG) ? 1'b1 : wl_q;
    assign cal_error  = (state == S_ERR);

    // Configuration word with the word-length bit patched in.
    always_comb begin
        xfer_wdata         = CFG_INIT;
        xfer_wdata[WL_POS] = long_word;
    end

    adcseq_cal_timer #(.LIMIT(CAL_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_CAL),
        .expired (expired)
    );

    adcseq_chan_track #(.CH_W(CH_W), .DISCARD_N(DISCARD_N)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .new_chan  (req_chan),
        .read_done (rd_done),
        .chan_sel  (chan_sel),
        .drop_now  (drop_now)
    );

    adcseq_fmt #(.CH_W(CH_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_done && !drop_now),
        .long_mode (wl_q),
        .rdata     (xfer_rdata),
        .tag       (chan_sel),
        .valid     (smp_valid),
        .raw       (smp_raw),
        .twos      (smp_twos),
        .chan      (smp_chan)
    );

    assert_cfg_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_write) |-> (xfer_wdata[23:21] == 3'b001 && xfer_wdata[20:18] == 3'b000));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_error |=> (cal_error && !xfer_req));

    assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> $stable(chan_sel));

    assert_read_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_req) && !xfer_write) |-> $past(!adc_rdy_n));

    assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(xfer_done && !xfer_write));

    assert_idle_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !xfer_req) |=> ($stable(chan_sel) && !(xfer_req && !xfer_write)));
endmodule

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
    localparam int TMO = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  req_chan = 3'd0;
    logic        long_word = 1'b0;
    logic        adc_rdy_n = 1'b1;
    logic        xfer_req, xfer_write, xfer_long;
    logic [23:0] xfer_wdata;
    logic        xfer_done = 1'b0;
    logic [23:0] xfer_rdata = 24'd0;
    logic [2:0]  chan_sel, smp_chan;
    logic        smp_valid, cal_error;
    logic [23:0] smp_raw, smp_twos;

    always #2.5 clk = ~clk;

    adcseq_top #(.CH_W(3), .CAL_TIMEOUT(TMO), .DISCARD_N(1)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .req_chan(req_chan),
        .long_word(long_word), .adc_rdy_n(adc_rdy_n),
        .xfer_req(xfer_req), .xfer_write(xfer_write), .xfer_long(xfer_long),
        .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
        .chan_sel(chan_sel), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .smp_twos(smp_twos), .smp_chan(smp_chan), .cal_error(cal_error)
    );

    int checks = 0, failures = 0, cycles = 0;
    logic        do_conv = 1'b0;
    logic [23:0] model_data = 24'd0;
    int          nreads = 0, nwrites = 0, mcnt = 0, vcnt = 0;
    logic [23:0] last_wdata = 24'd0, v_raw = 24'd0, v_twos = 24'd0;
    logic        last_long = 1'b0;
    logic [2:0]  v_chan = 3'd0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Port master and converter model: 4-cycle transfers, ready drops on request.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        xfer_done <= 1'b0;
        if (!rst_n) begin
            mcnt <= 0;
            adc_rdy_n <= 1'b1;
        end else begin
            if (do_conv) adc_rdy_n <= 1'b0;
            if (xfer_req && !xfer_done) begin
                if (mcnt == 3) begin
                    xfer_done  <= 1'b1;
                    mcnt       <= 0;
                    xfer_rdata <= model_data;
                    if (xfer_write) begin
                        nwrites    <= nwrites + 1;
                        last_wdata <= xfer_wdata;
                    end else begin
                        nreads    <= nreads + 1;
                        last_long <= xfer_long;
                        adc_rdy_n <= 1'b1;
                    end
                end else mcnt <= mcnt + 1;
            end
            if (smp_valid) begin
                vcnt   <= vcnt + 1;
                v_raw  <= smp_raw;
                v_twos <= smp_twos;
                v_chan <= smp_chan;
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cycles > 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic do_reset(input logic wl, input logic en);
        @(negedge clk);
        rst_n = 1'b0; long_word = wl; enable = en; req_chan = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chan_sel == 3'd0 && !smp_valid && !cal_error, "reset", {chan_sel, smp_valid, cal_error}, 0);
    endtask

    task automatic ready_pulse();
        @(negedge clk) do_conv = 1'b1;
        @(negedge clk) do_conv = 1'b0;
    endtask

    task automatic wait_reads(input int r0);
        for (int i = 0; i < 100 && nreads == r0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic conv(input logic [23:0] d);
        int r0;
        r0 = nreads;
        model_data = d;
        ready_pulse();
        wait_reads(r0);
    endtask

    function automatic logic [23:0] pat(input int k);
        case (k % 8)
            0: pat = 24'h000000;  1: pat = 24'h800000;
            2: pat = 24'hFFFFFF;  3: pat = 24'h7FFFFF;
            4: pat = 24'h000001;  5: pat = 24'h12B456;
            6: pat = 24'hFE7CBA;  default: pat = 24'h408000;
        endcase
    endfunction

    task automatic check_sample(input logic wl, input logic [23:0] d, input logic [2:0] ch, input int v0);
        logic [23:0] er, et;
        er = wl ? d : (d & 24'h00FFFF);
        et = wl ? (er - 24'h800000) : (er - 24'h008000);
        chk(vcnt == v0 + 1, "R6 kept", vcnt, v0 + 1);
        chk(v_raw == er, "R7 raw", v_raw, er);
        chk(v_twos == et, "R8 twos", v_twos, et);
        chk(v_chan == ch, "R9 tag", v_chan, ch);
        chk(last_long == wl, "R7 length", last_long, wl);
    endtask

    task automatic run_mode(input logic wl);
        int w0, v0, r0;
        logic [23:0] d;
        w0 = nwrites;
        do_reset(wl, 1'b0);
        for (int i = 0; i < 50 && nwrites == w0; i++) @(negedge clk);
        chk(last_wdata == (24'h22004E | (24'(wl) << 15)), "R1 word", last_wdata, 24'h22004E | (24'(wl) << 15));
        r0 = nreads;
        repeat (10) @(negedge clk);
        chk(nreads == r0 && !cal_error, "R2 wait", nreads - r0, 0);
        // Calibration finishes while disabled: nothing may be read.
        v0 = vcnt;
        conv(24'hABCDEF);
        chk(nreads == r0 && vcnt == v0, "R10 disabled", nreads - r0, 0);
        req_chan = 3'd5;
        repeat (5) @(negedge clk);
        chk(chan_sel == 3'd0, "R10 chan", chan_sel, 0);
        req_chan = 3'd0;
        enable = 1'b1;
        wait_reads(r0);
        check_sample(wl, 24'hABCDEF, 3'd0, v0);
        chk(nwrites == w0 + 1, "R2 one write", nwrites - w0, 1);
        // Sweep every channel code, ending back on code 0.
        for (int k = 1; k <= 8; k++) begin
            req_chan = 3'(k % 8);
            repeat (3) @(negedge clk);
            chk(chan_sel == 3'(k % 8), "R4 select", chan_sel, k % 8);
            v0 = vcnt;
            conv(24'h5A5A5A);
            chk(vcnt == v0, "R6 drop", vcnt, v0);
            d = pat(k);
            conv(d);
            check_sample(wl, d, 3'(k % 8), v0);
        end
        // Request a switch while a read is in flight.
        v0 = vcnt;
        r0 = nreads;
        model_data = pat(wl ? 5 : 6);
        ready_pulse();
        for (int i = 0; i < 50 && !(xfer_req && !xfer_write); i++) @(negedge clk);
        req_chan = 3'd3;
        @(negedge clk);
        chk(chan_sel == 3'd0, "R4 deferred", chan_sel, 0);
        wait_reads(r0);
        check_sample(wl, pat(wl ? 5 : 6), 3'd0, v0);
        chk(chan_sel == 3'd3, "R4 applied", chan_sel, 3);
        v0 = vcnt;
        conv(24'h111111);
        chk(vcnt == v0, "R6 drop late", vcnt, v0);
        conv(24'h8000FF);
        check_sample(wl, 24'h8000FF, 3'd3, v0);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        // Calibration that never ends.
        begin
            int w0, r0;
            w0 = nwrites;
            r0 = nreads;
            do_reset(1'b0, 1'b1);
            for (int i = 0; i < 50 && nwrites == w0; i++) @(negedge clk);
            repeat (TMO - 10) @(negedge clk);
            chk(!cal_error, "R3 early", cal_error, 0);
            repeat (20) @(negedge clk);
            chk(cal_error, "R3 timeout", cal_error, 1);
            ready_pulse();
            repeat (20) @(negedge clk);
            chk(cal_error && !xfer_req, "R3 sticky", {cal_error, xfer_req}, 2'b10);
            chk(nreads == r0 && nwrites == w0 + 1, "R3 idle", nreads - r0, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule